// File: doc/BRIEF.md
# Serial Command Sequencer for a Capture Buffer

This block sits behind a UART receiver and transmitter and turns a stream of one-letter command bytes into the control actions of a small sampling instrument. Two letters each take one ASCII digit argument that sets a 3-bit setting: one picks the capture depth and one picks the sample rate. One letter takes two raw bytes that form a two-step trigger pattern. The remaining letters start actions that run for many cycles: a capture start, a pseudo-random fill of the sample memory, a raw binary readback and a readable hex dump.

A capture start first raises the rate select and the read strobe while holding the capture engine in reset. It then releases reset and waits for the engine's done flag. If a trigger pattern has been loaded, reset stays held until the probe bus has matched the first pattern byte and, in a later cycle, the second. Readback drives a synchronous RAM read port with one cycle of latency and pushes each byte through a valid/ready transmit handshake.

Top module: `sc_cmd_top`

## Requirements
- R1: The byte 's' (0x73), followed by an ASCII digit '0'..'7' (0x30..0x37), loads that digit's value into `size_sel` on the clock edge that accepts the digit.
- R2: The byte 'c' (0x63), followed by an ASCII digit '0'..'7', loads that digit's value into `rate_sel` on the clock edge that accepts the digit.
- R3: An argument byte that is not '0'..'7' leaves the target setting unchanged, and the decoder returns to waiting for a command.
- R4: In idle, an unknown command byte is dropped without effect. Any byte that arrives while a fill, readback, dump or capture is running is dropped without effect.
- R5: After 't' (0x74), `cap_clk_sel` and `cap_rd_strobe` go high for at least one cycle while `cap_reset` stays high. `cap_reset` then goes low and stays low until `cap_done` is seen high. In the cycle after that, `cap_reset` is high again and both strobes are low.
- R6: The byte 'l' (0x6C), followed by two bytes A and B, arms a trigger. Once armed, a 't' holds `cap_reset` high with the strobes up until `probe_in` has equalled A and, in a later cycle, equals B. Reset is released in the cycle after the match with B.
- R7: The byte 'r' (0x72) sends memory addresses 0 through DEPTH-1 in order, one raw byte each, and nothing more. While `tx_ready` is low, `tx_valid` stays high and `tx_data` is held.
- R8: The byte 'd' (0x64) sends each memory byte from address 0 upward as three characters: the upper hex nibble, the lower hex nibble (digits '0'..'9', letters 'A'..'F' in upper case) and a space (0x20).
- R9: The byte 'w' (0x77) writes every address from 0 upward, one per cycle, with the low 8 bits of a 16-bit LFSR. The LFSR starts at the seed (0xACE1 by default) and steps once after each write. Its feedback bit is the XOR of state bits 15, 13, 12 and 10, and it shifts in at bit 0.
- R10: After reset, `size_sel` and `rate_sel` are 0, `cap_reset` is 1, and `cap_clk_sel`, `cap_rd_strobe`, `tx_valid` and `mem_wr_en` are 0. No trigger is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_data` valid |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | `tx_data` is ready to be taken |
| tx_ready | input | 1 | Transmitter takes the byte at this edge when valid |
| size_sel | output | 3 | Capture depth setting |
| rate_sel | output | 3 | Sample rate setting |
| probe_in | input | 8 | Probe bus watched for the trigger pattern |
| cap_clk_sel | output | 1 | Routes the sample clock to the capture engine |
| cap_rd_strobe | output | 1 | Capture-mode memory strobe enable |
| cap_reset | output | 1 | Holds the capture engine in reset when high |
| cap_done | input | 1 | Capture engine has finished |
| mem_addr | output | ADDR_W | Memory address for reads and writes |
| mem_rd_en | output | 1 | Read request; data arrives one cycle later |
| mem_rd_data | input | 8 | Read data |
| mem_wr_en | output | 1 | Write enable |
| mem_wr_data | output | 8 | Write data |

## Verification
The setting registers are driven from a table of letter/argument pairs. Valid digits at both ends of the range separate correct digit decoding from an off-by-one error. Digits just above and below the range ('8', '9', '/'), and a stray unknown letter, show whether bad input leaks into a register or leaves the decoder stuck in an argument state. Readback runs under a transmitter that stalls at intervals, which exposes lost or repeated bytes. Capture starts are tried without and with a trigger, and the trigger run holds the first pattern byte for several cycles to show that one match alone does not release reset.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int BYTE_W = 8;
  localparam int ARG_W  = 3;

  localparam logic [BYTE_W-1:0] K_SIZE  = 8'h73;
  localparam logic [BYTE_W-1:0] K_RATE  = 8'h63;
  localparam logic [BYTE_W-1:0] K_TRIG  = 8'h6C;
  localparam logic [BYTE_W-1:0] K_START = 8'h74;
  localparam logic [BYTE_W-1:0] K_RAW   = 8'h72;
  localparam logic [BYTE_W-1:0] K_HEX   = 8'h64;
  localparam logic [BYTE_W-1:0] K_FILL  = 8'h77;
  localparam logic [BYTE_W-1:0] K_SPACE = 8'h20;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARG_SIZE, ST_ARG_RATE, ST_LD_A, ST_LD_B,
    ST_CAP_SEL, ST_CAP_TRG1, ST_CAP_TRG2, ST_CAP_RUN,
    ST_RD_REQ, ST_RD_LATCH, ST_RD_SEND, ST_WR_RUN
  } sc_state_t;

  function automatic logic is_arg_digit(input logic [BYTE_W-1:0] b);
    return (b >= 8'h30) && (b < 8'h30 + (1 << ARG_W));
  endfunction

  function automatic logic [ARG_W-1:0] digit_val(input logic [BYTE_W-1:0] b);
    return ARG_W'(b - 8'h30);
  endfunction

  function automatic logic [15:0] lfsr16_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [BYTE_W-1:0] hex_ascii(input logic [3:0] n);
    return (n > 4'd9) ? (8'h41 + BYTE_W'(n) - 8'd10) : (8'h30 + BYTE_W'(n));
  endfunction

endpackage

// File: rtl/sc_arg_reg.sv
module sc_arg_reg
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [ARG_W-1:0]  val
);
  logic take;
  assign take = load && is_arg_digit(byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= '0;
    else if (take) val <= digit_val(byte_in);
  end
endmodule

// File: rtl/sc_lfsr.sv
module sc_lfsr
  import sc_pkg::*;
#(
  parameter logic [15:0] SEED = 16'hACE1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  output logic [BYTE_W-1:0] rand_byte
);
  logic [15:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (restart) state_q <= SEED;
    else if (step)    state_q <= lfsr16_step(state_q);
  end

  assign rand_byte = state_q[BYTE_W-1:0];
endmodule

// File: rtl/sc_tx_fmt.sv
module sc_tx_fmt
  import sc_pkg::*;
(
  input  logic [BYTE_W-1:0] data_byte,
  input  logic              hex_mode,
  input  logic [1:0]        char_idx,
  output logic [BYTE_W-1:0] ch
);
  always_comb begin
    if (!hex_mode) ch = data_byte;
    else begin
      unique case (char_idx)
        2'd0:    ch = hex_ascii(data_byte[7:4]);
        2'd1:    ch = hex_ascii(data_byte[3:0]);
        default: ch = K_SPACE;
      endcase
    end
  end
endmodule

// File: rtl/sc_cmd_top.sv
module sc_cmd_top
  import sc_pkg::*;
#(
  parameter int          ADDR_W = 4,
  parameter logic [15:0] SEED   = 16'hACE1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [2:0]        size_sel,
  output logic [2:0]        rate_sel,
  input  logic [7:0]        probe_in,
  output logic              cap_clk_sel,
  output logic              cap_rd_strobe,
  output logic              cap_reset,
  input  logic              cap_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wr_data
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [1:0]        HEX_LAST  = 2'd2;

  sc_state_t         state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [7:0]        txbuf_q;
  logic              hex_q;
  logic [1:0]        idx_q;
  logic [7:0]        trig_a_q, trig_b_q;
  logic              armed_q;

  // named events
  logic idle_rx, size_take, rate_take, tx_fire, byte_sent, at_last, fill_go, in_capture;
  assign idle_rx    = (state_q == ST_IDLE) && rx_valid;
  assign size_take  = (state_q == ST_ARG_SIZE) && rx_valid;
  assign rate_take  = (state_q == ST_ARG_RATE) && rx_valid;
  assign tx_fire    = tx_valid && tx_ready;
  assign byte_sent  = tx_fire && (!hex_q || idx_q == HEX_LAST);
  assign at_last    = (ptr_q == LAST_ADDR);
  assign fill_go    = idle_rx && (rx_data == K_FILL);
  assign in_capture = (state_q == ST_CAP_SEL) || (state_q == ST_CAP_TRG1) ||
                      (state_q == ST_CAP_TRG2) || (state_q == ST_CAP_RUN);

  sc_arg_reg u_size (.clk(clk), .rst_n(rst_n), .load(size_take), .byte_in(rx_data), .val(size_sel));
  sc_arg_reg u_rate (.clk(clk), .rst_n(rst_n), .load(rate_take), .byte_in(rx_data), .val(rate_sel));

  sc_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .restart(fill_go),
    .step(state_q == ST_WR_RUN), .rand_byte(mem_wr_data)
  );

  sc_tx_fmt u_fmt (.data_byte(txbuf_q), .hex_mode(hex_q), .char_idx(idx_q), .ch(tx_data));

  assign tx_valid      = (state_q == ST_RD_SEND);
  assign mem_addr      = ptr_q;
  assign mem_rd_en     = (state_q == ST_RD_REQ);
  assign mem_wr_en     = (state_q == ST_WR_RUN);
  assign cap_clk_sel   = in_capture;
  assign cap_rd_strobe = in_capture;
  assign cap_reset     = (state_q != ST_CAP_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      txbuf_q  <= '0;
      hex_q    <= 1'b0;
      idx_q    <= '0;
      trig_a_q <= '0;
      trig_b_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rx_valid) begin
          ptr_q <= '0;
          case (rx_data)
            K_SIZE:  state_q <= ST_ARG_SIZE;
            K_RATE:  state_q <= ST_ARG_RATE;
            K_TRIG:  state_q <= ST_LD_A;
            K_START: state_q <= ST_CAP_SEL;
            K_RAW:   begin hex_q <= 1'b0; state_q <= ST_RD_REQ; end
            K_HEX:   begin hex_q <= 1'b1; state_q <= ST_RD_REQ; end
            K_FILL:  state_q <= ST_WR_RUN;
            default: state_q <= ST_IDLE;
          endcase
        end
        ST_ARG_SIZE, ST_ARG_RATE: if (rx_valid) state_q <= ST_IDLE;
        ST_LD_A: if (rx_valid) begin
          trig_a_q <= rx_data;
          state_q  <= ST_LD_B;
        end
        ST_LD_B: if (rx_valid) begin
          trig_b_q <= rx_data;
          armed_q  <= 1'b1;
          state_q  <= ST_IDLE;
        end
        ST_CAP_SEL:  state_q <= armed_q ? ST_CAP_TRG1 : ST_CAP_RUN;
        ST_CAP_TRG1: if (probe_in == trig_a_q) state_q <= ST_CAP_TRG2;
        ST_CAP_TRG2: if (probe_in == trig_b_q) state_q <= ST_CAP_RUN;
        ST_CAP_RUN:  if (cap_done) state_q <= ST_IDLE;
        ST_RD_REQ:   state_q <= ST_RD_LATCH;
        ST_RD_LATCH: begin
          txbuf_q <= mem_rd_data;
          idx_q   <= '0;
          state_q <= ST_RD_SEND;
        end
        ST_RD_SEND: begin
          if (tx_fire && !byte_sent) idx_q <= idx_q + 2'd1;
          if (byte_sent) begin
            if (at_last) state_q <= ST_IDLE;
            else begin
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_WR_RUN: begin
          if (at_last) state_q <= ST_IDLE;
          else         ptr_q   <= ptr_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_cmd_chk.sv
module sc_cmd_chk #(
  parameter int ADDR_W = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic [2:0]        size_sel,
  input logic [2:0]        rate_sel,
  input logic              cap_reset,
  input logic              cap_clk_sel,
  input logic              cap_rd_strobe,
  input logic              cap_done,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr
);
  p_size_needs_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(size_sel) |-> $past(rx_valid));

  p_rate_needs_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_sel) |-> $past(rx_valid));

  p_release_after_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_reset) |-> ($past(cap_clk_sel) && $past(cap_rd_strobe)));

  p_done_ends_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_reset && cap_done) |=> (cap_reset && !cap_clk_sel));

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_fill_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_wr_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

bind sc_cmd_top sc_cmd_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .size_sel(size_sel),
  .rate_sel(rate_sel), .cap_reset(cap_reset), .cap_clk_sel(cap_clk_sel),
  .cap_rd_strobe(cap_rd_strobe), .cap_done(cap_done),
  .mem_wr_en(mem_wr_en), .mem_addr(mem_addr)
);

// File: tb/sc_cmd_top_tb_top.sv
module sc_cmd_top_tb_top;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready = 1'b1;
  logic [2:0] size_sel, rate_sel;
  logic [7:0] probe_in = '0;
  logic cap_clk_sel, cap_rd_strobe, cap_reset;
  logic cap_done = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_rd_en, mem_wr_en;
  logic [7:0] mem_rd_data, mem_wr_data;

  always #5 clk = ~clk;

  sc_cmd_top #(.ADDR_W(ADDR_W), .SEED(SEED)) dut_i (.*);

  // bench memory model, one-cycle read latency
  logic [7:0] mem [DEPTH];
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= mem[mem_addr];
  end

  // transmit collector with optional stalls
  logic [7:0] rxq [128];
  int rxn = 0;
  int rdy_mode = 0;
  logic [3:0] rdy_cnt = '0;
  always @(negedge clk) begin
    rdy_cnt = rdy_cnt + 4'd1;
    tx_ready = (rdy_mode == 0) || (rdy_cnt[1:0] != 2'b01);
    if (tx_valid && tx_ready && rxn < 128) begin
      rxq[rxn] = tx_data;
      rxn++;
    end
  end

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + 8'(n)) : (8'h37 + 8'(n));
  endfunction

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] arg;
    logic [2:0] sz;
    logic [2:0] rt;
  } vec_t;

  // R1 R2 R3 R4 register vectors: command, argument, expected size, expected rate
  localparam vec_t VECS [9] = '{
    '{8'h73, 8'h35, 3'd5, 3'd0},
    '{8'h63, 8'h33, 3'd5, 3'd3},
    '{8'h73, 8'h39, 3'd5, 3'd3},
    '{8'h63, 8'h38, 3'd5, 3'd3},
    '{8'h73, 8'h2F, 3'd5, 3'd3},
    '{8'h71, 8'h33, 3'd5, 3'd3},
    '{8'h63, 8'h37, 3'd5, 3'd7},
    '{8'h73, 8'h30, 3'd0, 3'd7},
    '{8'h73, 8'h37, 3'd7, 3'd7}
  };

  task automatic run_tests();
    logic [15:0] s;
    int base;
    // R10 reset state
    @(negedge clk);
    chk(size_sel == 3'd0 && rate_sel == 3'd0, "R10 settings", {size_sel, rate_sel}, 0);
    chk(cap_reset && !cap_clk_sel && !cap_rd_strobe, "R10 capture lines",
        {cap_reset, cap_clk_sel, cap_rd_strobe}, 3'b100);
    chk(!tx_valid && !mem_wr_en, "R10 tx/mem idle", {tx_valid, mem_wr_en}, 0);

    foreach (VECS[i]) begin
      send_byte(VECS[i].cmd);
      send_byte(VECS[i].arg);
      chk(size_sel == VECS[i].sz, $sformatf("R1/R3/R4 vec %0d size", i), size_sel, VECS[i].sz);
      chk(rate_sel == VECS[i].rt, $sformatf("R2/R3/R4 vec %0d rate", i), rate_sel, VECS[i].rt);
    end

    // R9 fill, with R4 bytes arriving while busy
    send_byte(8'h77);
    send_byte(8'h73);
    send_byte(8'h36);
    repeat (DEPTH + 4) @(negedge clk);
    chk(size_sel == 3'd7, "R4 byte during fill ignored", size_sel, 7);
    chk(!mem_wr_en, "R9 fill finished", mem_wr_en, 0);
    s = SEED;
    for (int k = 0; k < DEPTH; k++) begin
      chk(mem[k] == s[7:0], $sformatf("R9 fill addr %0d", k), mem[k], s[7:0]);
      s = {s[14:0], ^(s & 16'hB400)};
    end

    // R7 raw readback with stalls
    rdy_mode = 1;
    base = rxn;
    send_byte(8'h72);
    for (int w = 0; w < 400 && rxn - base < DEPTH; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(rxn - base == DEPTH, "R7 byte count", rxn - base, DEPTH);
    for (int k = 0; k < DEPTH; k++)
      chk(rxq[base + k] == mem[k], $sformatf("R7 raw byte %0d", k), rxq[base + k], mem[k]);

    // R8 hex dump
    rdy_mode = 0;
    base = rxn;
    send_byte(8'h64);
    for (int w = 0; w < 400 && rxn - base < 3 * DEPTH; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(rxn - base == 3 * DEPTH, "R8 char count", rxn - base, 3 * DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      chk(rxq[base + 3*k] == hexc(mem[k][7:4]), "R8 high nibble", rxq[base + 3*k], hexc(mem[k][7:4]));
      chk(rxq[base + 3*k + 1] == hexc(mem[k][3:0]), "R8 low nibble", rxq[base + 3*k + 1], hexc(mem[k][3:0]));
      chk(rxq[base + 3*k + 2] == 8'h20, "R8 separator", rxq[base + 3*k + 2], 8'h20);
    end

    // R5 untriggered store
    send_byte(8'h74);
    chk(cap_clk_sel && cap_rd_strobe && cap_reset, "R5 setup phase",
        {cap_clk_sel, cap_rd_strobe, cap_reset}, 3'b111);
    @(negedge clk);
    chk(!cap_reset && cap_clk_sel, "R5 reset released", {cap_reset, cap_clk_sel}, 2'b01);
    send_byte(8'h73);
    repeat (3) @(negedge clk);
    chk(!cap_reset, "R5 waits for done", cap_reset, 0);
    cap_done = 1'b1;
    @(negedge clk);
    cap_done = 1'b0;
    chk(cap_reset && !cap_clk_sel && !cap_rd_strobe, "R5 capture ended",
        {cap_reset, cap_clk_sel, cap_rd_strobe}, 3'b100);
    send_byte(8'h33);
    chk(size_sel == 3'd7, "R4 byte during capture ignored", size_sel, 7);

    // R6 triggered store
    send_byte(8'h6C);
    send_byte(8'hA5);
    send_byte(8'h3C);
    probe_in = 8'h00;
    send_byte(8'h74);
    repeat (3) @(negedge clk);
    chk(cap_reset && cap_clk_sel, "R6 held before first match", {cap_reset, cap_clk_sel}, 2'b11);
    probe_in = 8'hA5;
    @(negedge clk);
    chk(cap_reset, "R6 held after first match", cap_reset, 1);
    repeat (2) @(negedge clk);
    chk(cap_reset, "R6 held until second match", cap_reset, 1);
    probe_in = 8'h3C;
    @(negedge clk);
    chk(!cap_reset && cap_rd_strobe, "R6 released after second match", {cap_reset, cap_rd_strobe}, 2'b01);
    cap_done = 1'b1;
    @(negedge clk);
    cap_done = 1'b0;
    chk(cap_reset, "R6 capture ended", cap_reset, 1);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_tests();
      begin
        repeat (60000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule